// File: doc/BRIEF.md
# Modulo Address Correction Unit

This unit forms the effective address for one data address generator that walks circular buffers. Each request carries a pointer taken from a working register, a signed step or offset, an addressing mode and the inclusive start and end byte addresses of the buffer. The unit adds the step to the pointer and, when circular addressing applies to that register, folds any result that has run off the far end of the buffer back inside it. Only the boundary that lies in the direction of travel is tested.

The result comes out as two values. The effective address goes to the memory access. The writeback value goes to the pointer register, together with an enable and the register index. In pre-modify and post-modify modes the corrected pointer is written back. In register-plus-offset mode the address is corrected but the pointer is left unchanged. Addresses are byte addresses, and a word step is 2. A request is captured on one clock edge, and its results are valid until the next edge.

Top module: `modulo_agu`

## Requirements
- R1: While reset is asserted and after it is released, before any request, out_valid and wb_en are 0 and eff_addr is 0.
- R2: out_valid is high exactly in the cycle after a cycle with req_valid high. All other outputs in that cycle belong to that request.
- R3: Circular addressing is active and the step is non-negative. If pointer+step is greater than buf_end, the result is pointer+step minus the length (buf_end-buf_start+1). Otherwise the result is pointer+step. A sum equal to buf_end is kept, and a sum below buf_start is not corrected.
- R4: Circular addressing is active and the step is negative. If pointer+step is less than buf_start, the result is pointer+step plus the length. Otherwise the result is pointer+step. A sum above buf_end is not corrected.
- R5: A sum that lands several bytes past a boundary is corrected by the same single length adjustment. For a pointer inside the buffer and a step magnitude no larger than the length, the corrected result lies within [buf_start, buf_end].
- R6: Mode 2'd0 (pre-modify) sets eff_addr and wb_data to the corrected result, with wb_en at 1.
- R7: Mode 2'd1 (post-modify) sets eff_addr to the unmodified pointer and wb_data to the corrected result, with wb_en at 1.
- R8: Mode 2'd2 (register plus offset) sets eff_addr to the corrected result, with wb_en at 0.
- R9: Mode 2'd3 (plain indirect) sets eff_addr to the pointer and ignores the step, with wb_en at 0.
- R10: Circular addressing is active only when mod_en is 1 and reg_idx equals mod_sel. In every other case the plain 16-bit sum pointer+step passes through unchanged.
- R11: wb_idx equals the reg_idx of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| mod_en | input | 1 | Circular addressing enable for this generator |
| mod_sel | input | 4 | Working register that circular addressing applies to |
| reg_idx | input | 4 | Working register supplying the pointer |
| mode | input | 2 | 0 pre-modify, 1 post-modify, 2 register plus offset, 3 plain indirect |
| base_ptr | input | 16 | Pointer register contents |
| delta | input | 16 | Signed step or offset, two's complement |
| buf_start | input | 16 | First byte address of the buffer |
| buf_end | input | 16 | Last byte address of the buffer (inclusive) |
| out_valid | output | 1 | Results valid for the previous cycle's request |
| eff_addr | output | 16 | Effective address |
| wb_en | output | 1 | Pointer writeback enable |
| wb_idx | output | 4 | Register to write back |
| wb_data | output | 16 | Pointer writeback value |

## Verification
The first set of directed cases puts sums exactly on each boundary, one step past it, and several bytes past it. These cases separate an equality-only test from a greater-than test, and a correct length from one that is off by one. A second set moves the pointer toward the boundary that should not be tested: an incrementing sum below the start and a decrementing sum above the end. These cases show that only the boundary in the direction of travel is checked. The same sums are then repeated with the enable cleared, with a register index that does not match, and in each of the four modes. This separates the corrected value from the plain sum, and the effective address from the writeback. Seeded random requests inside random even-aligned buffers then mix all of these inputs.

// File: rtl/modagu_pkg.sv
package modagu_pkg;
  typedef enum logic [1:0] {
    MODE_PRE    = 2'd0,
    MODE_POST   = 2'd1,
    MODE_OFFSET = 2'd2,
    MODE_PLAIN  = 2'd3
  } addr_mode_e;
endpackage

// File: rtl/mac_sum_dir.sv
// Adds the step to the pointer and derives the direction of travel.
module mac_sum_dir #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] delta,
  output logic [AW-1:0] sum,
  output logic          incr
);
  function automatic logic [AW-1:0] add_step(input logic [AW-1:0] a, input logic [AW-1:0] d);
    return a + d;
  endfunction

  always_comb begin
    sum  = add_step(base, delta);
    incr = ~delta[AW-1];
  end
endmodule

// File: rtl/mac_bound_fix.sv
// Folds a sum that has run past the boundary in the direction of travel.
module mac_bound_fix #(
  parameter int AW = 16
) (
  input  logic          active,
  input  logic          incr,
  input  logic [AW-1:0] sum,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] corr
);
  function automatic logic [AW-1:0] wrap_addr(
    input logic [AW-1:0] a,
    input logic [AW-1:0] l,
    input logic [AW-1:0] h,
    input logic          up
  );
    logic [AW-1:0] len;
    len = h - l + AW'(1);
    if (up && (a > h))  return a - len;
    if (!up && (a < l)) return a + len;
    return a;
  endfunction

  always_comb begin
    if (active) corr = wrap_addr(sum, lo, hi, incr);
    else        corr = sum;
  end
endmodule

// File: rtl/mac_route.sv
// Chooses the effective address and the writeback value for each mode.
module mac_route #(
  parameter int AW = 16
) (
  input  logic                   valid,
  input  modagu_pkg::addr_mode_e mode,
  input  logic [AW-1:0]          base,
  input  logic [AW-1:0]          corr,
  output logic [AW-1:0]          ea,
  output logic                   wb_en,
  output logic [AW-1:0]          wb_data
);
  import modagu_pkg::*;

  always_comb begin
    wb_data = corr;
    unique case (mode)
      MODE_PRE:    begin ea = corr; wb_en = valid; end
      MODE_POST:   begin ea = base; wb_en = valid; end
      MODE_OFFSET: begin ea = corr; wb_en = 1'b0;  end
      default:     begin ea = base; wb_en = 1'b0;  end
    endcase
  end
endmodule

// File: rtl/modulo_agu.sv
module modulo_agu #(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          mod_en,
  input  logic [RW-1:0] mod_sel,
  input  logic [RW-1:0] reg_idx,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] base_ptr,
  input  logic [AW-1:0] delta,
  input  logic [AW-1:0] buf_start,
  input  logic [AW-1:0] buf_end,
  output logic          out_valid,
  output logic [AW-1:0] eff_addr,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [AW-1:0] wb_data
);
  import modagu_pkg::*;

  logic          q_valid;
  logic          q_mod_en;
  logic [RW-1:0] q_sel;
  logic [RW-1:0] q_idx;
  addr_mode_e    q_mode;
  logic [AW-1:0] q_base;
  logic [AW-1:0] q_delta;
  logic [AW-1:0] q_start;
  logic [AW-1:0] q_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_mod_en <= 1'b0;
      q_sel    <= '0;
      q_idx    <= '0;
      q_mode   <= MODE_PLAIN;
      q_base   <= '0;
      q_delta  <= '0;
      q_start  <= '0;
      q_end    <= '0;
    end else begin
      q_valid <= req_valid;
      if (req_valid) begin
        q_mod_en <= mod_en;
        q_sel    <= mod_sel;
        q_idx    <= reg_idx;
        q_mode   <= addr_mode_e'(mode);
        q_base   <= base_ptr;
        q_delta  <= delta;
        q_start  <= buf_start;
        q_end    <= buf_end;
      end
    end
  end

  // Internal events, named so that the checker can refer to them.
  logic          mod_active;
  logic          step_incr;
  logic [AW-1:0] raw_sum;
  logic [AW-1:0] fixed_sum;
  logic          route_wb;

  assign mod_active = q_mod_en && (q_idx == q_sel);

  mac_sum_dir #(.AW(AW)) u_sum (
    .base  (q_base),
    .delta (q_delta),
    .sum   (raw_sum),
    .incr  (step_incr)
  );

  mac_bound_fix #(.AW(AW)) u_fix (
    .active (mod_active),
    .incr   (step_incr),
    .sum    (raw_sum),
    .lo     (q_start),
    .hi     (q_end),
    .corr   (fixed_sum)
  );

  mac_route #(.AW(AW)) u_route (
    .valid   (q_valid),
    .mode    (q_mode),
    .base    (q_base),
    .corr    (fixed_sum),
    .ea      (eff_addr),
    .wb_en   (route_wb),
    .wb_data (wb_data)
  );

  assign out_valid = q_valid;
  assign wb_en     = route_wb;
  assign wb_idx    = q_idx;
endmodule

// File: rtl/modulo_agu_chk.sv
module modulo_agu_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          out_valid,
  input logic          wb_en,
  input logic [AW-1:0] eff_addr,
  input logic [AW-1:0] wb_data,
  input logic [1:0]    q_mode,
  input logic [AW-1:0] q_base,
  input logic [AW-1:0] q_delta,
  input logic [AW-1:0] q_start,
  input logic [AW-1:0] q_end,
  input logic [AW-1:0] raw_sum,
  input logic [AW-1:0] fixed_sum,
  input logic          mod_active,
  input logic          step_incr
);
  logic [AW-1:0] len;
  logic [AW-1:0] mag;
  logic          in_buf;
  assign len    = q_end - q_start + AW'(1);
  assign mag    = step_incr ? q_delta : (~q_delta + AW'(1));
  assign in_buf = (q_base >= q_start) && (q_base <= q_end) && (mag <= len);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  assert_inside_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mod_active && in_buf && (q_start <= q_end)) |->
      ((fixed_sum >= q_start) && (fixed_sum <= q_end)));

  assert_pre_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_mode == 2'd0) |-> (wb_en && eff_addr == wb_data));

  assert_post_ea_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_mode == 2'd1) |-> (wb_en && eff_addr == q_base));

  assert_offset_nowb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_mode == 2'd2) |-> (!wb_en && eff_addr == fixed_sum));

  assert_plain_ea_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && q_mode == 2'd3) |-> (!wb_en && eff_addr == q_base));

  assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !mod_active) |-> (fixed_sum == raw_sum));

  assert_idle_nowb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !wb_en);
endmodule

bind modulo_agu modulo_agu_chk #(.AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .out_valid  (out_valid),
  .wb_en      (wb_en),
  .eff_addr   (eff_addr),
  .wb_data    (wb_data),
  .q_mode     (q_mode),
  .q_base     (q_base),
  .q_delta    (q_delta),
  .q_start    (q_start),
  .q_end      (q_end),
  .raw_sum    (raw_sum),
  .fixed_sum  (fixed_sum),
  .mod_active (mod_active),
  .step_incr  (step_incr)
);

// File: tb/modulo_agu_tb.sv
module modulo_agu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        mod_en = 1'b0;
  logic [3:0]  mod_sel = '0;
  logic [3:0]  reg_idx = '0;
  logic [1:0]  mode = '0;
  logic [15:0] base_ptr = '0;
  logic [15:0] delta = '0;
  logic [15:0] buf_start = '0;
  logic [15:0] buf_end = '0;
  logic        out_valid;
  logic [15:0] eff_addr;
  logic        wb_en;
  logic [3:0]  wb_idx;
  logic [15:0] wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modulo_agu dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mod_en(mod_en),
    .mod_sel(mod_sel), .reg_idx(reg_idx), .mode(mode), .base_ptr(base_ptr),
    .delta(delta), .buf_start(buf_start), .buf_end(buf_end),
    .out_valid(out_valid), .eff_addr(eff_addr), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // Direction-aware fold, written in plain integer arithmetic.
  function automatic int model_target(int b, int d, int s, int e, bit on);
    int t;
    t = b + d;
    if (on) begin
      if (d >= 0 && t > e) t = t - (e - s + 1);
      else if (d < 0 && t < s) t = t + (e - s + 1);
    end
    return t & 32'hFFFF;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(string req, bit me, logic [3:0] sel, logic [3:0] ri,
                     logic [1:0] md, int b, int d, int s, int e);
    int t;
    int x_ea;
    bit x_wb;
    req_valid = 1'b1; mod_en = me; mod_sel = sel; reg_idx = ri; mode = md;
    base_ptr = 16'(b); delta = 16'(d); buf_start = 16'(s); buf_end = 16'(e);
    t = model_target(b, d, s, e, me && (sel == ri));
    case (md)
      2'd0: begin x_ea = t; x_wb = 1'b1; end
      2'd1: begin x_ea = b; x_wb = 1'b1; end
      2'd2: begin x_ea = t; x_wb = 1'b0; end
      default: begin x_ea = b; x_wb = 1'b0; end
    endcase
    @(negedge clk);
    check("R2", "out_valid", int'(out_valid), 1);
    check(req, "eff_addr", int'(eff_addr), x_ea);
    check(req, "wb_en", int'(wb_en), int'(x_wb));
    if (x_wb) check(req, "wb_data", int'(wb_data), t);
    check("R11", "wb_idx", int'(wb_idx), int'(ri));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", int'(out_valid), 0);
    check("R1", "wb_en in reset", int'(wb_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "eff_addr after reset", int'(eff_addr), 0);
    check("R1", "wb_en after reset", int'(wb_en), 0);

    // Buffer 0x2000..0x201F, length 0x20.
    run("R3", 1, 4'd3, 4'd3, 2'd0, 'h201E, 2, 'h2000, 'h201F);     // one step past end
    run("R3", 1, 4'd3, 4'd3, 2'd0, 'h201C, 2, 'h2000, 'h201F);     // lands on end-1, kept
    run("R3", 1, 4'd3, 4'd3, 2'd0, 'h201E, 0, 'h2000, 'h201F);     // zero step kept
    run("R3", 1, 4'd3, 4'd3, 2'd0, 'h1F00, 4, 'h2000, 'h201F);     // below start, incrementing
    run("R4", 1, 4'd3, 4'd3, 2'd1, 'h2000, -2, 'h2000, 'h201F);    // under start
    run("R4", 1, 4'd3, 4'd3, 2'd0, 'h2100, -2, 'h2000, 'h201F);    // above end, decrementing
    run("R5", 1, 4'd3, 4'd3, 2'd2, 'h2010, 'h16, 'h2000, 'h201F);  // jump past end
    run("R5", 1, 4'd3, 4'd3, 2'd0, 'h2004, -'h0A, 'h2000, 'h201F); // jump below start
    run("R6", 1, 4'd5, 4'd5, 2'd0, 'h2018, 'h10, 'h2000, 'h201F);
    run("R7", 1, 4'd5, 4'd5, 2'd1, 'h201E, 4, 'h2000, 'h201F);
    run("R8", 1, 4'd5, 4'd5, 2'd2, 'h2002, -4, 'h2000, 'h201F);
    run("R9", 1, 4'd5, 4'd5, 2'd3, 'h2030, 2, 'h2000, 'h201F);
    run("R10", 0, 4'd3, 4'd3, 2'd0, 'h201E, 2, 'h2000, 'h201F);
    run("R10", 1, 4'd2, 4'd3, 2'd0, 'h201E, 2, 'h2000, 'h201F);
    run("R10", 1, 4'd2, 4'd3, 2'd1, 'h2000, -2, 'h2000, 'h201F);

    req_valid = 1'b0;
    @(negedge clk);
    check("R2", "out_valid idle", int'(out_valid), 0);
    check("R2", "wb_en idle", int'(wb_en), 0);

    for (int i = 0; i < 400; i++) begin
      int s, len, b, d;
      logic [3:0] ri, sel;
      s   = 'h1000 + 2 * int'($urandom % 'h1800);
      len = 2 * (1 + int'($urandom % 64));
      b   = s + 2 * int'($urandom % (len / 2));
      d   = 2 * int'($urandom % (len / 2 + 1));
      if ($urandom % 2) d = -d;
      ri  = 4'($urandom);
      sel = (($urandom % 8) == 0) ? ri ^ 4'd1 : ri;
      run("R5", ($urandom % 8) != 0, sel, ri, 2'($urandom), b, d, s, s + len - 1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule